// File: doc/BRIEF.md
# Double-Buffered Converter Write Front End

This block sits between a 16-bit parallel write bus and a unipolar digital-to-analog converter core. It holds two registers in series. A staging register captures words from the bus. A converter register takes the staging word, or the bus word directly, and drives the core. All four controls are active low: a write strobe, a staging-register select, a converter-register select, and a clear. Each rising clock edge samples the strobe and the two selects and decodes them into one of four operations. OP_HOLD changes nothing. OP_LOAD_IN writes the bus into the staging register. OP_LOAD_CNV copies the staging register into the converter register. OP_PASS writes the bus into both registers in the same edge.

Stored words are two's complement. The core expects offset binary, so the block inverts the top bit of the converter register on its way out. A stored 0000h therefore gives half scale, 7FFFh gives full scale and 8000h gives zero. The clear acts asynchronously and drives both registers to 0000h, which is mid-scale, without waiting for a clock edge. A one-cycle flag marks every change of the converter register, whatever caused it.

Several instances can share the strobe and the converter-register select. Each one is preloaded through its own staging select, and one shared strobe then moves all outputs on the same edge. Single-buffered use holds the staging select low so that every strobe reaches the output.

Top module: `dac_bus_frontend`

## Requirements
- R1: After power-up reset both registers hold 0000h, so core_code reads 8000h and code_changed is 0.
- R2: OP_LOAD_IN (wr_n=0, sel_in_n=0, sel_cnv_n=1 at a rising edge) stores the bus into the staging register and leaves core_code unchanged.
- R3: OP_LOAD_CNV (wr_n=0, sel_in_n=1, sel_cnv_n=0 at a rising edge) copies the staging register into the converter register. core_code shows the new value after that edge.
- R4: OP_HOLD (wr_n=1, or both selects at 1) changes neither register, whatever the bus carries.
- R5: OP_PASS (wr_n=0, both selects at 0, clr_n=1) stores the bus into both registers on one edge. core_code reflects the bus word after that single edge.
- R6: clr_n=0 forces both registers to 0000h at once, without a clock edge. While clr_n stays low, no write operation takes effect.
- R7: core_code equals the converter word with bit 15 inverted: 7FFFh gives FFFFh, 8000h gives 0000h, 0000h gives 8000h and 0001h gives 8001h.
- R8: code_changed is 1 for exactly one cycle after the converter register takes a new value. It stays 0 when a load rewrites the same value.
- R9: With sel_in_n held at 0, each cycle with wr_n=0 and sel_cnv_n=0 moves the bus word to core_code. Each cycle with wr_n=1 holds it.
- R10: Two instances that share wr_n and sel_cnv_n, preloaded with different words, both change core_code and assert code_changed on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; controls are sampled on its rising edge |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| bus_data | input | 16 | Two's-complement data word from the bus |
| wr_n | input | 1 | Write strobe, active low |
| sel_in_n | input | 1 | Staging-register select, active low |
| sel_cnv_n | input | 1 | Converter-register select, active low |
| clr_n | input | 1 | Asynchronous clear to mid-scale, active low |
| core_code | output | 16 | Offset-binary code for the converter core |
| code_changed | output | 1 | One-cycle flag on each change of the converter register |

## Verification
The bench first loads only the staging register and confirms that the output does not move. A design that wired the bus straight through would fail that check. It then drops the clear between clock edges and reads mid-scale before the next edge, so a synchronous clear shows up. A converter-only load after the clear must give mid-scale, which catches a clear that misses the staging register. Writes are attempted while the clear is held low, to check that they do nothing. Boundary words (7FFFh, 8000h, 0000h, 0001h) expose a wrong bit in the offset-binary recoding. A reload of the same value must leave the change flag low, which catches a flag raised on every write. A pass-through must land in one edge, which catches a design that routes it through the staging register and adds a cycle.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;
    typedef enum logic [1:0] {
        OP_HOLD     = 2'd0,
        OP_LOAD_IN  = 2'd1,
        OP_LOAD_CNV = 2'd2,
        OP_PASS     = 2'd3
    } latch_op_e;
endpackage

// File: rtl/dac_ctrl_decode.sv
module dac_ctrl_decode
    import dac_if_pkg::*;
(
    input  logic      wr_n,
    input  logic      sel_in_n,
    input  logic      sel_cnv_n,
    output latch_op_e op
);
    always_comb begin
        unique case ({wr_n, sel_in_n, sel_cnv_n})
            3'b000:  op = OP_PASS;
            3'b001:  op = OP_LOAD_IN;
            3'b010:  op = OP_LOAD_CNV;
            default: op = OP_HOLD;
        endcase
    end
endmodule

// File: rtl/dac_latch_pair.sv
module dac_latch_pair
    import dac_if_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter logic [DATA_W-1:0] CLR_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  latch_op_e         op,
    input  logic [DATA_W-1:0] bus_data,
    output logic [DATA_W-1:0] stage_q,
    output logic [DATA_W-1:0] cnv_q
);
    logic arst_n;
    assign arst_n = rst_n & clr_n;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            stage_q <= CLR_WORD;
            cnv_q   <= CLR_WORD;
        end else begin
            unique case (op)
                OP_LOAD_IN:  stage_q <= bus_data;
                OP_LOAD_CNV: cnv_q   <= stage_q;
                OP_PASS: begin
                    stage_q <= bus_data;
                    cnv_q   <= bus_data;
                end
                default: ;
            endcase
        end
    end

    p_load_in_r2: assert property (@(posedge clk) disable iff (!arst_n)
        op == OP_LOAD_IN |=> stage_q == $past(bus_data) && $stable(cnv_q));
    p_load_cnv_r3: assert property (@(posedge clk) disable iff (!arst_n)
        op == OP_LOAD_CNV |=> cnv_q == $past(stage_q) && $stable(stage_q));
    p_hold_r4: assert property (@(posedge clk) disable iff (!arst_n)
        op == OP_HOLD |=> $stable(cnv_q) && $stable(stage_q));
    p_pass_r5: assert property (@(posedge clk) disable iff (!arst_n)
        op == OP_PASS |=> cnv_q == $past(bus_data) && stage_q == $past(bus_data));
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> cnv_q == CLR_WORD && stage_q == CLR_WORD);
endmodule

// File: rtl/dac_code_map.sv
module dac_code_map #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic [DATA_W-1:0] cnv_q,
    output logic [DATA_W-1:0] core_code,
    output logic              code_changed
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cnv_q;
    end

    assign core_code    = {~cnv_q[MSB], cnv_q[MSB-1:0]};
    assign code_changed = (cnv_q != prev_q);

    p_pulse_once_r8: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        code_changed |=> !code_changed || $changed(core_code));
    p_pulse_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        $stable(core_code) |-> !code_changed);
endmodule

// File: rtl/dac_bus_frontend.sv
module dac_bus_frontend
    import dac_if_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              wr_n,
    input  logic              sel_in_n,
    input  logic              sel_cnv_n,
    input  logic              clr_n,
    output logic [DATA_W-1:0] core_code,
    output logic              code_changed
);
    latch_op_e         op;
    logic [DATA_W-1:0] stage_q;
    logic [DATA_W-1:0] cnv_q;

    dac_ctrl_decode u_decode (
        .wr_n      (wr_n),
        .sel_in_n  (sel_in_n),
        .sel_cnv_n (sel_cnv_n),
        .op        (op)
    );

    dac_latch_pair #(.DATA_W(DATA_W), .CLR_WORD('0)) u_latches (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (clr_n),
        .op       (op),
        .bus_data (bus_data),
        .stage_q  (stage_q),
        .cnv_q    (cnv_q)
    );

    dac_code_map #(.DATA_W(DATA_W)) u_map (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_n        (clr_n),
        .cnv_q        (cnv_q),
        .core_code    (core_code),
        .code_changed (code_changed)
    );

    p_msb_invert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        core_code[DATA_W-1] != cnv_q[DATA_W-1]);
endmodule

// File: tb/test_dac_bus_frontend.sv
module test_dac_bus_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_a = '0;
    logic [15:0] bus_b = '0;
    logic        wr_n = 1'b1;
    logic        sel_in_n = 1'b1;
    logic        sel_in_b_n = 1'b1;
    logic        sel_cnv_n = 1'b1;
    logic        clr_n = 1'b1;
    logic [15:0] code_a, code_b;
    logic        chg_a, chg_b;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dac_bus_frontend i_dac_bus_frontend (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_a), .wr_n(wr_n),
        .sel_in_n(sel_in_n), .sel_cnv_n(sel_cnv_n), .clr_n(clr_n),
        .core_code(code_a), .code_changed(chg_a));

    dac_bus_frontend i_dac_bus_frontend_b (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_b), .wr_n(wr_n),
        .sel_in_n(sel_in_b_n), .sel_cnv_n(sel_cnv_n), .clr_n(clr_n),
        .core_code(code_b), .code_changed(chg_b));

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive controls at a falling edge, pass one rising edge, return at the next falling edge.
    task automatic step(input logic w, input logic si, input logic sc, input logic [15:0] d);
        wr_n = w; sel_in_n = si; sel_cnv_n = sc; bus_a = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        step(1'b1, 1'b1, 1'b1, 16'hDEAD);
    endtask

    task automatic t_reset();
        check("R1 reset code", code_a, 16'h8000);
        check("R1 reset flag", {15'd0, chg_a}, 16'd0);
    endtask

    task automatic t_load_in_then_cnv();
        step(1'b0, 1'b0, 1'b1, 16'h1234);
        check("R2 staging load hidden", code_a, 16'h8000);
        check("R2 no flag", {15'd0, chg_a}, 16'd0);
        step(1'b0, 1'b1, 1'b0, 16'hFFFF);
        check("R3 converter load", code_a, 16'h9234);
        check("R8 flag after change", {15'd0, chg_a}, 16'd1);
        idle();
        check("R8 flag one cycle", {15'd0, chg_a}, 16'd0);
    endtask

    task automatic t_hold();
        step(1'b1, 1'b0, 1'b0, 16'h5555);
        check("R4 strobe high holds", code_a, 16'h9234);
        step(1'b0, 1'b1, 1'b1, 16'h6666);
        check("R4 both selects high hold", code_a, 16'h9234);
        step(1'b0, 1'b1, 1'b0, 16'h7777);
        check("R4 staging untouched by hold", code_a, 16'h9234);
        check("R8 same value no flag", {15'd0, chg_a}, 16'd0);
    endtask

    task automatic t_pass();
        step(1'b0, 1'b0, 1'b0, 16'h0F0F);
        check("R5 pass in one edge", code_a, 16'h8F0F);
        check("R8 flag on pass", {15'd0, chg_a}, 16'd1);
        idle();
    endtask

    task automatic t_coding();
        step(1'b0, 1'b0, 1'b0, 16'h7FFF);
        check("R7 full scale", code_a, 16'hFFFF);
        step(1'b0, 1'b0, 1'b0, 16'h8000);
        check("R7 zero", code_a, 16'h0000);
        step(1'b0, 1'b0, 1'b0, 16'h0000);
        check("R7 half scale", code_a, 16'h8000);
        step(1'b0, 1'b0, 1'b0, 16'h0001);
        check("R7 half plus one", code_a, 16'h8001);
        idle();
    endtask

    task automatic t_clear();
        step(1'b0, 1'b0, 1'b0, 16'h1111);
        step(1'b0, 1'b0, 1'b1, 16'h2222);
        idle();
        check("R6 before clear", code_a, 16'h9111);
        clr_n = 1'b0;
        #1;
        check("R6 clear without edge", code_a, 16'h8000);
        check("R8 flag on clear", {15'd0, chg_a}, 16'd1);
        @(negedge clk);
        step(1'b0, 1'b0, 1'b0, 16'h5555);
        check("R6 writes blocked in clear", code_a, 16'h8000);
        clr_n = 1'b1;
        idle();
        step(1'b0, 1'b1, 1'b0, 16'h3333);
        check("R6 staging cleared", code_a, 16'h8000);
        idle();
    endtask

    task automatic t_single_buffer();
        step(1'b0, 1'b0, 1'b0, 16'hC000);
        check("R9 strobe moves word", code_a, 16'h4000);
        step(1'b1, 1'b0, 1'b0, 16'h4000);
        check("R9 strobe high holds", code_a, 16'h4000);
        step(1'b0, 1'b0, 1'b0, 16'h4000);
        check("R9 second word", code_a, 16'hC000);
        idle();
    endtask

    task automatic t_simultaneous();
        logic [15:0] a0, b0;
        a0 = code_a; b0 = code_b;
        step(1'b0, 1'b0, 1'b1, 16'h1234);
        bus_b = 16'hABCD; sel_in_b_n = 1'b0;
        step(1'b0, 1'b1, 1'b1, 16'h0000);
        sel_in_b_n = 1'b1;
        check("R10 preload hidden a", code_a, a0);
        check("R10 preload hidden b", code_b, b0);
        step(1'b0, 1'b1, 1'b0, 16'h0000);
        check("R10 shared update a", code_a, 16'h9234);
        check("R10 shared update b", code_b, 16'h2BCD);
        check("R10 flags together", {14'd0, chg_a, chg_b}, 16'd3);
        idle();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_in_then_cnv();
        t_hold();
        t_pass();
        t_coding();
        t_clear();
        t_single_buffer();
        t_simultaneous();
        done = 1'b1;
        finish_run();
    end

    initial begin
        #100000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end
endmodule